// File: doc/BRIEF.md
# Load Data Extension Formatter

This block sits at the end of a load pipeline, after the data returns from memory. It turns the raw bytes of a byte, halfword, word or doubleword access into the 64-bit value that is written back to an integer register. On request it sign-extends the field. It can also reverse the byte order of the field before the upper bits are zero-filled. The result is registered, so it appears one clock after the request together with a valid strobe.

The loaded field is right-aligned in `ld_data`. The byte that came from the lowest memory address is the most significant byte of the field. Bit 63 of a port is the most significant bit, so that bit 63 here corresponds to bit 0 in big-endian numbering. Any input bits above the field are junk and have no effect. The combination of sign extension with a byte access, or of sign extension with byte reversal, is rejected. Such a request produces an error strobe in place of a result.

Top module: `ldfmt_top`

## Requirements
- R1: Access size encoding is 0 = byte, 1 = halfword, 2 = word, 3 = doubleword. For a byte access, `res_data[7:0]` equals `ld_data[7:0]` and `res_data[63:8]` is zero.
- R2: For a halfword access with `ld_sext`=0, `res_data[15:0]` equals `ld_data[15:0]` and bits 63..16 are zero.
- R3: For a halfword access with `ld_sext`=1, bits 63..16 are all copies of `ld_data[15]`.
- R4: For a word access, `res_data[31:0]` equals `ld_data[31:0]`. Bits 63..32 are zero when `ld_sext`=0 and copies of `ld_data[31]` when `ld_sext`=1.
- R5: A doubleword access without byte reversal passes all 64 bits unchanged, whatever the value of `ld_sext`.
- R6: With `ld_swap`=1, a halfword access swaps the two bytes of `ld_data[15:0]` and zero-fills bits 63..16.
- R7: With `ld_swap`=1, a word access reverses the four bytes of `ld_data[31:0]`: byte k moves to byte 3-k. Bits 63..32 are zero-filled.
- R8: With `ld_swap`=1, a doubleword access reverses all eight bytes: byte k moves to byte 7-k.
- R9: `ld_swap`=1 on a byte access without sign extension has no effect on the result.
- R10: A request with `ld_sext`=1 together with either a byte access or `ld_swap`=1 gives `res_err`=1 and `res_data`=0, with `res_valid`=1.
- R11: `res_valid` is high in exactly the cycle after each cycle in which `ld_valid` is high. `res_err` is high only while `res_valid` is high.
- R12: A synchronous active-high `rst` clears `res_valid`, `res_err` and `res_data` at the next clock edge, even if `ld_valid` is high at the same time.
- R13: Input bits above the selected access size do not affect `res_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ld_valid | input | 1 | Request strobe for this cycle |
| ld_size | input | 2 | Access size code (0 byte, 1 half, 2 word, 3 double) |
| ld_sext | input | 1 | Sign-extend the loaded field |
| ld_swap | input | 1 | Reverse the byte order of the loaded field |
| ld_data | input | 64 | Raw loaded bytes, right-aligned, first memory byte most significant |
| res_valid | output | 1 | Result strobe, one cycle after `ld_valid` |
| res_err | output | 1 | Illegal flag combination detected |
| res_data | output | 64 | Formatted register value |

## Verification
Byte reversal and zero-fill of the upper bits act on the same request in the same cycle. The bench provokes this with reversed halfword and word accesses whose input bits above the field carry all-ones junk. It judges the result by checking two things: that only field bytes were permuted, and that none of the junk was swapped into the field or left above it. The illegal-flag path also meets the pipeline timing. Back-to-back streams mix rejected and accepted requests, and each cycle's error and data are compared against the request issued one clock earlier.

// File: rtl/ldfmt_pkg.sv
package ldfmt_pkg;
    localparam int XLEN   = 64;
    localparam int BYTE_W = 8;
    localparam int SZ_W   = 2;

    typedef enum logic [SZ_W-1:0] {
        SZ_BYTE   = 2'd0,
        SZ_HALF   = 2'd1,
        SZ_WORD   = 2'd2,
        SZ_DOUBLE = 2'd3
    } size_e;
endpackage

// File: rtl/ldfmt_swap.sv
// Byte-lane reversal of a right-aligned field; one network per access size.
module ldfmt_swap #(
    parameter int DATA_W = ldfmt_pkg::XLEN,
    parameter int BYTE_W = ldfmt_pkg::BYTE_W,
    parameter int SZ_W   = ldfmt_pkg::SZ_W
) (
    input  logic [DATA_W-1:0] din,
    input  logic [SZ_W-1:0]   size,
    input  logic              en,
    output logic [DATA_W-1:0] dout
);
    localparam int NB  = DATA_W / BYTE_W;
    localparam int NSZ = 1 << SZ_W;

    logic [NSZ-1:0][DATA_W-1:0] rev;

    for (genvar s = 0; s < NSZ; s++) begin : g_size
        localparam int LEN = ((1 << s) > NB) ? NB : (1 << s);
        for (genvar b = 0; b < NB; b++) begin : g_lane
            if (b < LEN) begin : g_in
                assign rev[s][b*BYTE_W +: BYTE_W] = din[(LEN-1-b)*BYTE_W +: BYTE_W];
            end else begin : g_out
                assign rev[s][b*BYTE_W +: BYTE_W] = '0;
            end
        end
    end

    assign dout = en ? rev[size] : din;
endmodule

// File: rtl/ldfmt_extend.sv
// Masks a right-aligned field to its size and fills the upper part.
module ldfmt_extend #(
    parameter int DATA_W = ldfmt_pkg::XLEN,
    parameter int BYTE_W = ldfmt_pkg::BYTE_W,
    parameter int SZ_W   = ldfmt_pkg::SZ_W
) (
    input  logic [DATA_W-1:0] din,
    input  logic [SZ_W-1:0]   size,
    input  logic              sext,
    output logic [DATA_W-1:0] dout
);
    localparam int NB = DATA_W / BYTE_W;

    logic [DATA_W-1:0] mask;
    logic              sgn;
    int unsigned       len;

    always_comb begin
        len  = 32'd1 << size;
        mask = '0;
        sgn  = 1'b0;
        for (int b = 0; b < NB; b++) begin
            if (b < int'(len)) mask[b*BYTE_W +: BYTE_W] = '1;
            if (b == int'(len) - 1) sgn = din[b*BYTE_W + BYTE_W - 1];
        end
        dout = (din & mask) | ((sext && sgn) ? ~mask : '0);
    end
endmodule

// File: rtl/ldfmt_check.sv
// Flags request combinations that have no defined result.
module ldfmt_check #(
    parameter int SZ_W = ldfmt_pkg::SZ_W
) (
    input  logic [SZ_W-1:0] size,
    input  logic            sext,
    input  logic            swap,
    output logic            illegal
);
    import ldfmt_pkg::*;
    assign illegal = sext && (swap || size == SZ_BYTE);
endmodule

// File: rtl/ldfmt_top.sv
module ldfmt_top #(
    parameter int DATA_W = ldfmt_pkg::XLEN,
    parameter int BYTE_W = ldfmt_pkg::BYTE_W,
    parameter int SZ_W   = ldfmt_pkg::SZ_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_valid,
    input  logic [SZ_W-1:0]   ld_size,
    input  logic              ld_sext,
    input  logic              ld_swap,
    input  logic [DATA_W-1:0] ld_data,
    output logic              res_valid,
    output logic              res_err,
    output logic [DATA_W-1:0] res_data
);
    import ldfmt_pkg::*;

    typedef struct packed {
        logic              valid;
        logic              err;
        logic [DATA_W-1:0] data;
    } stage_t;

    stage_t            st_d, st_q;
    logic [DATA_W-1:0] swapped;
    logic [DATA_W-1:0] extended;
    logic              illegal;

    ldfmt_swap #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .SZ_W(SZ_W)) u_swap (
        .din (ld_data),
        .size(ld_size),
        .en  (ld_swap),
        .dout(swapped)
    );

    ldfmt_extend #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .SZ_W(SZ_W)) u_ext (
        .din (swapped),
        .size(ld_size),
        .sext(ld_sext),
        .dout(extended)
    );

    ldfmt_check #(.SZ_W(SZ_W)) u_chk (
        .size   (ld_size),
        .sext   (ld_sext),
        .swap   (ld_swap),
        .illegal(illegal)
    );

    always_comb begin
        st_d       = '0;
        st_d.valid = ld_valid;
        if (ld_valid) begin
            st_d.err  = illegal;
            st_d.data = illegal ? '0 : extended;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign res_valid = st_q.valid;
    assign res_err   = st_q.err;
    assign res_data  = st_q.data;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        ld_valid |=> res_valid);  // R11
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
        !ld_valid |=> !res_valid);  // R11
    AST_ERR_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        res_err |-> res_valid);  // R11
    AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (rst)
        res_err |-> (res_data == '0));  // R10
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!res_valid && !res_err));  // R12
    AST_WORD_ZERO_UPPER: assert property (@(posedge clk) disable iff (rst)
        (ld_valid && !ld_sext && ld_size == SZ_WORD) |=> (res_data[DATA_W-1:32] == '0));  // R4
    AST_HALF_SIGN_FILL: assert property (@(posedge clk) disable iff (rst)
        (ld_valid && ld_sext && !ld_swap && ld_size == SZ_HALF && ld_data[15])
        |=> (&res_data[DATA_W-1:16]));  // R3
endmodule

// File: tb/sim_ldfmt_top.sv
`timescale 1ns/1ps
module sim_ldfmt_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        ld_valid;
    logic [1:0]  ld_size;
    logic        ld_sext;
    logic        ld_swap;
    logic [63:0] ld_data;
    logic        res_valid;
    logic        res_err;
    logic [63:0] res_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    ldfmt_top u0 (
        .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_size(ld_size),
        .ld_sext(ld_sext), .ld_swap(ld_swap), .ld_data(ld_data),
        .res_valid(res_valid), .res_err(res_err), .res_data(res_data)
    );

    // Reference: {err, data} from the requirement text.
    function automatic logic [64:0] ref_fmt(int sz, bit sg, bit sw, logic [63:0] d);
        logic [7:0]  b [8];
        logic [63:0] r = '0;
        int n = 1 << sz;
        if (sg && (sw || sz == 0)) return {1'b1, 64'd0};
        for (int i = 0; i < 8; i++) b[i] = d[8*i +: 8];
        for (int i = 0; i < n; i++) r[8*i +: 8] = sw ? b[n-1-i] : b[i];
        if (sg && r[8*n-1]) for (int i = n; i < 8; i++) r[8*i +: 8] = 8'hFF;
        return {1'b0, r};
    endfunction

    task automatic chk(string req, logic [64:0] act, logic [64:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(bit v, int sz, bit sg, bit sw, logic [63:0] d);
        ld_valid = v; ld_size = 2'(sz); ld_sext = sg; ld_swap = sw; ld_data = d;
    endtask

    // One request, result checked one clock later against a literal and the reference.
    task automatic op(string req, int sz, bit sg, bit sw, logic [63:0] d,
                      logic [63:0] exp_d, bit exp_e);
        @(negedge clk) drive(1, sz, sg, sw, d);
        @(negedge clk) drive(0, 0, 0, 0, '1);
        chk({req, " valid"}, {64'd0, res_valid}, 65'd1);
        chk(req, {res_err, res_data}, {exp_e, exp_d});
        chk({req, " ref"}, {res_err, res_data}, ref_fmt(sz, sg, sw, d));
    endtask

    task automatic t_reset();
        rst = 1'b1; drive(1, 3, 0, 0, 64'hDEAD_BEEF_0123_4567);
        repeat (2) @(negedge clk);
        chk("R12 reset", {res_valid, res_err, res_data[62:0]}, 65'd0);
        chk("R12 reset data", {1'b0, res_data}, 65'd0);
        rst = 1'b0; drive(0, 0, 0, 0, '0);
        @(negedge clk);
        chk("R11 idle", {64'd0, res_valid}, 65'd0);
    endtask

    task automatic t_zero_ext();
        op("R1 byte",       0, 0, 0, 64'hFFFF_FFFF_FFFF_FF9C, 64'h9C, 0);
        op("R2 half",       1, 0, 0, 64'h0000_0000_0000_8001, 64'h8001, 0);
        op("R4 word zero",  2, 0, 0, 64'h0000_0000_8765_4321, 64'h8765_4321, 0);
        op("R5 double",     3, 0, 0, 64'h8123_4567_89AB_CDEF, 64'h8123_4567_89AB_CDEF, 0);
        op("R5 double sx",  3, 1, 0, 64'hF000_0000_0000_0001, 64'hF000_0000_0000_0001, 0);
    endtask

    task automatic t_sign_ext();
        op("R3 half neg",   1, 1, 0, 64'h0000_0000_0000_8001, 64'hFFFF_FFFF_FFFF_8001, 0);
        op("R3 half pos",   1, 1, 0, 64'hFFFF_FFFF_FFFF_7FFE, 64'h0000_0000_0000_7FFE, 0);
        op("R4 word neg",   2, 1, 0, 64'h0000_0000_8000_0000, 64'hFFFF_FFFF_8000_0000, 0);
        op("R4 word pos",   2, 1, 0, 64'hFFFF_FFFF_7FFF_FFFF, 64'h0000_0000_7FFF_FFFF, 0);
    endtask

    task automatic t_swap();
        op("R6 half swap",  1, 0, 1, 64'h0000_0000_0000_12F4, 64'hF412, 0);
        op("R7 word swap",  2, 0, 1, 64'h0000_0000_8899_AABB, 64'hBBAA_9988, 0);
        op("R8 dbl swap",   3, 0, 1, 64'h0102_0304_0506_0708, 64'h0807_0605_0403_0201, 0);
        op("R9 byte swap",  0, 0, 1, 64'h0000_0000_0000_00A5, 64'hA5, 0);
    endtask

    task automatic t_junk();
        op("R13 half junk", 1, 0, 0, 64'hFFFF_FFFF_FFFF_0102, 64'h0102, 0);
        op("R13 swap junk", 1, 0, 1, 64'hFFFF_FFFF_FFFF_0102, 64'h0201, 0);
        op("R7 swap junk",  2, 0, 1, 64'hFFFF_FFFF_0102_0380, 64'h8003_0201, 0);
    endtask

    task automatic t_illegal();
        op("R10 sx byte",   0, 1, 0, 64'h80, 64'd0, 1);
        op("R10 sx swap",   2, 1, 1, 64'h8000_0000, 64'd0, 1);
        op("R10 sx swap d", 3, 1, 1, 64'h1, 64'd0, 1);
        @(negedge clk);
        chk("R11 err clear", {63'd0, res_valid, res_err}, 65'd0);
    endtask

    // Back-to-back: every combination, mixed legal and illegal, checked per cycle.
    task automatic t_stream();
        logic [64:0] prev;
        logic [63:0] d = 64'h0F1E_2D3C_4B5A_6978;
        bit have = 0;
        for (int rep = 0; rep < 3; rep++) begin
            for (int c = 0; c < 16; c++) begin
                @(negedge clk);
                if (have) begin
                    chk("R11 stream valid", {64'd0, res_valid}, 65'd1);
                    chk("R10 stream", {res_err, res_data}, prev);
                end
                d = d * 64'h5851_F42D_4C95_7F2D + 64'd1;
                drive(1, c & 3, c[2], c[3], d);
                prev = ref_fmt(c & 3, c[2], c[3], d);
                have = 1;
            end
        end
        @(negedge clk);
        chk("R10 stream last", {res_err, res_data}, prev);
        drive(0, 0, 0, 0, '0);
        @(negedge clk);
        chk("R11 stream end", {64'd0, res_valid}, 65'd0);
    endtask

    task automatic t_reset_mid();
        @(negedge clk) drive(1, 3, 0, 0, 64'h1234); rst = 1'b1;
        @(negedge clk) drive(0, 0, 0, 0, '0); rst = 1'b0;
        chk("R12 mid reset", {res_valid, res_err, res_data[62:0]}, 65'd0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R11 watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        t_reset();
        t_zero_ext();
        t_sign_ext();
        t_swap();
        t_junk();
        t_illegal();
        t_stream();
        t_reset_mid();
        done = 1'b1;
        summary();
        $finish;
    end
endmodule